// File: doc/BRIEF.md
# Page-Safe Burst Command Splitter

This block sits on the address side of a DMA read or write engine. A single transfer request carries a start address, a total number of beats and a beat size. The block breaks that request into a series of AXI4 INCR address commands. No command crosses a 4 KiB page, and none is longer than 256 beats. Each command goes out over a VALID/READY handshake, so it can drive either the write-address or the read-address channel of an AXI4 manager.

The length of each burst is worked out in two registered steps before the command's VALID is raised. The first step finds how many beats fit between the current address and the end of its page. The second step takes the smallest of that room, the beats still owed and the 256-beat cap. After each accepted command, the address moves forward by the bytes just covered and the owed count drops by the beats just issued. The block keeps issuing commands until nothing is left.

A one-cycle completion pulse marks the end of a request. The start address is assumed to be aligned to the beat size. Data channels, last-beat flagging and responses are handled elsewhere.

Top module: `burst_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_valid` and `done` are 0 and `req_ready` is 1.
- R2: For every command presented, the low 12 bits of `cmd_addr` plus ((`cmd_len`+1) << `cmd_size`) is at most 4096, so the first and last byte share all address bits above bit 11.
- R3: `cmd_len` holds the beat count minus one, so a command never describes more than 256 beats.
- R4: Each command's beat count equals the minimum of the beats left before the 4 KiB page end ((4096 minus the low 12 address bits) >> size), the beats still owed, and 256.
- R5: The first command starts at the request address, and each later command starts exactly at the previous command's address plus ((`cmd_len`+1) << `cmd_size`).
- R6: The beat counts of all commands for one request add up to the requested beat total.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, on the next cycle `cmd_valid` stays 1 and `cmd_addr`, `cmd_len`, `cmd_size` and `cmd_burst` are unchanged.
- R8: `cmd_burst` is 2'b01 (INCR) and `cmd_size` equals the request's `req_size` on every command.
- R9: `done` is 1 for exactly one cycle: the cycle after the clock edge where the final command of a request is accepted. After that cycle `req_ready` is 1 again.
- R10: A request with `req_beats` equal to 0 is ignored. No command appears, `done` stays 0 and `req_ready` stays 1.
- R11: `req_ready` is 0 while a request is in progress, and a `req_valid` pulse in that time does not change the commands issued.
- R12: `cmd_valid` rises on the second clock edge after the edge that accepts a request, and on the second edge after each non-final command handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_beats | input | BEATS_W | Total beats in the transfer |
| req_size | input | 3 | Beat size as log2 of bytes |
| cmd_valid | output | 1 | Address command is presented |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_len | output | 8 | Beats in the command minus one |
| cmd_size | output | 3 | Beat size as log2 of bytes |
| cmd_burst | output | 2 | Burst type, always INCR |
| done | output | 1 | One-cycle pulse after the final command is accepted |

## Verification
The bench aims at the following cases:

- Start addresses a few bytes or a single beat below a page end. A splitter that clips against the wrong room would emit a burst spilling into the next page.
- Requests larger than 256 beats inside one page. An unclipped design would overflow the 8-bit length field.
- Multi-page requests with an irregular ready pattern, where each command must hold steady through stalls. A design that advanced its address on VALID alone would leave gaps or overlaps, and the beat sum would then miss the total.
- A zero-beat request, and a request pulse during a busy transfer. A careless idle check would start a phantom transfer or hijack the running one.
- A request whose last page sits at the top of the address space, where the running address wraps around to zero.

// File: rtl/burst_splitter_pkg.sv
package burst_splitter_pkg;

  localparam int PAGE_BITS  = 12;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int ROOM_W     = PAGE_BITS + 1;
  localparam int MAX_BEATS  = 256;
  localparam int LEN_W      = 8;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROOM  = 2'd1,
    ST_CLIP  = 2'd2,
    ST_ISSUE = 2'd3
  } split_state_t;

endpackage

// File: rtl/page_room_stage.sv
module page_room_stage
  import burst_splitter_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [PAGE_BITS-1:0]  addr_lo,
  input  logic [2:0]            size,
  output logic [ROOM_W-1:0]     room_beats
);

  logic [ROOM_W-1:0] room_bytes;

  always_comb begin
    room_bytes = ROOM_W'(PAGE_BYTES) - {1'b0, addr_lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      room_beats <= '0;
    end else if (en) begin
      room_beats <= room_bytes >> size;
    end
  end

endmodule

// File: rtl/len_clip_stage.sv
module len_clip_stage
  import burst_splitter_pkg::*;
#(
  parameter int BEATS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [ROOM_W-1:0]    room_beats,
  input  logic [BEATS_W-1:0]   owed_beats,
  output logic [LEN_W-1:0]     len_m1
);

  localparam int CMP_W = (BEATS_W > ROOM_W) ? BEATS_W + 1 : ROOM_W + 1;

  logic [CMP_W-1:0] room_w, owed_w, cap_w, pick_a, pick;

  always_comb begin
    room_w = CMP_W'(room_beats);
    owed_w = CMP_W'(owed_beats);
    cap_w  = CMP_W'(MAX_BEATS);
    pick_a = (room_w < owed_w) ? room_w : owed_w;
    pick   = (pick_a < cap_w) ? pick_a : cap_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_m1 <= '0;
    end else if (en) begin
      len_m1 <= LEN_W'(pick - CMP_W'(1));
    end
  end

  // R4: a chosen burst never asks for more beats than are still owed
  p_len_within_owed_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> (CMP_W'(len_m1) + CMP_W'(1)) <= CMP_W'($past(owed_beats)));

  // R4: a chosen burst never exceeds the page room
  p_len_within_room_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> (CMP_W'(len_m1) + CMP_W'(1)) <= CMP_W'($past(room_beats)));

endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
  import burst_splitter_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BEATS_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BEATS_W-1:0] req_beats,
  input  logic [2:0]         req_size,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [7:0]         cmd_len,
  output logic [2:0]         cmd_size,
  output logic [1:0]         cmd_burst,
  output logic               done
);

  localparam int STEP_W = LEN_W + 1 + 7;

  split_state_t       st;
  logic [ADDR_W-1:0]  cur_addr;
  logic [BEATS_W-1:0] owed;
  logic [2:0]         size_q;
  logic [ROOM_W-1:0]  room_beats;
  logic [LEN_W-1:0]   len_m1;
  logic [LEN_W:0]     beats_now;
  logic [STEP_W-1:0]  step_bytes;
  logic               last_cmd;

  page_room_stage i_room (
    .clk        (clk),
    .rst        (rst),
    .en         (st == ST_ROOM),
    .addr_lo    (cur_addr[PAGE_BITS-1:0]),
    .size       (size_q),
    .room_beats (room_beats)
  );

  len_clip_stage #(.BEATS_W(BEATS_W)) i_clip (
    .clk        (clk),
    .rst        (rst),
    .en         (st == ST_CLIP),
    .room_beats (room_beats),
    .owed_beats (owed),
    .len_m1     (len_m1)
  );

  always_comb begin
    beats_now  = {1'b0, len_m1} + (LEN_W+1)'(1);
    step_bytes = STEP_W'(beats_now) << size_q;
    last_cmd   = (owed == BEATS_W'(beats_now));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_addr  <= '0;
      owed      <= '0;
      size_q    <= '0;
      cmd_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid && (req_beats != '0)) begin
            cur_addr <= req_addr;
            owed     <= req_beats;
            size_q   <= req_size;
            st       <= ST_ROOM;
          end
        end
        ST_ROOM: st <= ST_CLIP;
        ST_CLIP: begin
          st        <= ST_ISSUE;
          cmd_valid <= 1'b1;
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            cur_addr  <= cur_addr + ADDR_W'(step_bytes);
            owed      <= owed - BEATS_W'(beats_now);
            if (last_cmd) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_ROOM;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign cmd_addr  = cur_addr;
  assign cmd_len   = len_m1;
  assign cmd_size  = size_q;
  assign cmd_burst = BURST_INCR;

  // R7: a stalled command keeps VALID and its fields
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
      $stable(cmd_len) && $stable(cmd_size) && $stable(cmd_burst));

  // R2: a presented command stays inside its 4 KiB page
  p_page_safe_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (32'(cmd_addr[PAGE_BITS-1:0]) +
      ((32'(cmd_len) + 32'd1) << cmd_size)) <= 32'(PAGE_BYTES));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: no new request is taken while a command is offered
  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);

  // R12: VALID appears two edges after the length preparation starts
  p_prep_latency_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(st == ST_CLIP));

endmodule

// File: tb/test_burst_splitter.sv
module test_burst_splitter;

  localparam int ADDR_W  = 32;
  localparam int BEATS_W = 16;
  localparam int NVEC    = 8;

  // {addr, beats, size, stall, poke}
  localparam logic [ADDR_W+BEATS_W+3+2-1:0] VEC [NVEC] = '{
    {32'h0000_1000, 16'd16,   3'd2, 1'b0, 1'b0},
    {32'h0000_1F80, 16'd64,   3'd2, 1'b1, 1'b0},
    {32'h0000_0000, 16'd600,  3'd0, 1'b0, 1'b1},
    {32'h0001_0FF8, 16'd10,   3'd3, 1'b1, 1'b0},
    {32'h0000_2000, 16'd1024, 3'd4, 1'b1, 1'b0},
    {32'h0000_3FFF, 16'd3,    3'd0, 1'b0, 1'b0},
    {32'hFFFF_F000, 16'd512,  3'd3, 1'b1, 1'b1},
    {32'h0000_5F00, 16'd40,   3'd7, 1'b0, 1'b0}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [BEATS_W-1:0] req_beats = '0;
  logic [2:0]         req_size = '0;
  logic               cmd_valid;
  logic               cmd_ready = 1'b0;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [7:0]         cmd_len;
  logic [2:0]         cmd_size;
  logic [1:0]         cmd_burst;
  logic               done;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  burst_splitter #(.ADDR_W(ADDR_W), .BEATS_W(BEATS_W)) i_burst_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_size(req_size),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_burst(cmd_burst), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_len(input logic [ADDR_W-1:0] a, input int left, input int s);
    int room;
    int m;
    room = (4096 - int'(a[11:0])) >> s;
    m = (room < left) ? room : left;
    return (m < 256) ? m : 256;
  endfunction

  task automatic run_req(input logic [ADDR_W-1:0] a, input int n, input int s,
                         input bit stall, input bit poke);
    logic [ADDR_W-1:0] exp_addr;
    logic [ADDR_W-1:0] hold_addr;
    logic [7:0]        hold_len;
    int left, sum, since, exp_len, stall_cnt, nburst;
    bit pending, fin, hold_chk;
    exp_addr = a; left = n; sum = 0; since = 0; stall_cnt = 0; nburst = 0;
    pending = 0; fin = 0; hold_chk = 0; hold_addr = '0; hold_len = '0; exp_len = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_beats = 16'(n); req_size = 3'(s);
    for (int it = 0; it < 5000 && !fin; it++) begin
      @(negedge clk);
      req_valid = 1'b0;
      since++;
      if (left == 0) begin
        check(done == 1'b1, "R9 done after final handshake", done, 1);
        check(cmd_valid == 1'b0, "R9 no command after final", cmd_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", done, 0);
        check(req_ready == 1'b1, "R9 ready after done", req_ready, 1);
        fin = 1;
      end else begin
        if (done) check(1'b0, "R9 early done", done, 0);
        if (hold_chk) begin
          check(cmd_valid == 1'b1, "R7 valid held", cmd_valid, 1);
          check(cmd_addr == hold_addr, "R7 addr held", cmd_addr, hold_addr);
          check(cmd_len == hold_len, "R7 len held", cmd_len, hold_len);
        end
        hold_chk = 0;
        cmd_ready = 1'b0;
        if (cmd_valid) begin
          if (!pending) begin
            exp_len = model_len(exp_addr, left, s);
            check(since == 3, "R12 valid latency", since, 3);
            check(cmd_addr == exp_addr, "R5 contiguous address", cmd_addr, exp_addr);
            check(int'(cmd_len) == exp_len - 1, "R4 R3 burst length", cmd_len, exp_len - 1);
            check(cmd_size == 3'(s), "R8 size echoed", cmd_size, s);
            check(cmd_burst == 2'b01, "R8 INCR type", cmd_burst, 1);
            check(int'(cmd_addr[11:0]) + ((int'(cmd_len) + 1) << cmd_size) <= 4096,
                  "R2 page crossing", cmd_addr, exp_addr);
            pending = 1;
            if (poke && nburst == 0) begin
              check(req_ready == 1'b0, "R11 busy not ready", req_ready, 0);
              req_valid = 1'b1; req_addr = 32'h0000_0800; req_beats = 16'd7; req_size = 3'd1;
            end
          end
          if (!stall || (stall_cnt % 3 == 2)) begin
            cmd_ready = 1'b1;
            sum += exp_len;
            left -= exp_len;
            exp_addr = exp_addr + (ADDR_W'(exp_len) << s);
            pending = 0;
            since = 0;
            nburst++;
          end else begin
            hold_chk = 1; hold_addr = cmd_addr; hold_len = cmd_len;
          end
          stall_cnt++;
        end
      end
    end
    cmd_ready = 1'b0;
    check(fin, "R6 request completed", fin, 1);
    check(sum == n, "R6 beat total", sum, n);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1,
          "R1 state in reset", {cmd_valid, done, req_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1,
          "R1 state after reset", {cmd_valid, done, req_ready}, 3'b001);

    for (int v = 0; v < NVEC; v++) begin
      run_req(VEC[v][52:21], int'(VEC[v][20:5]), int'(VEC[v][4:2]), VEC[v][1], VEC[v][0]);
    end

    // R10: zero-beat request leaves the block idle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_4000; req_beats = 16'd0; req_size = 3'd2;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(cmd_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            "R10 zero request ignored", {cmd_valid, done, req_ready}, 3'b001);
      @(negedge clk);
    end

    // single beat just below a page end, directly after the zero request
    run_req(32'h0000_6FFC, 1, 2, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule